// File: doc/BRIEF.md
# Compare/Test Flag Unit with Branch Decision

This block derives the four arithmetic condition flags (zero, sign, carry, overflow) from two operands and decides whether a conditional jump should be taken. It has two operations. Compare subtracts the source operand from the destination operand. Test forms the bitwise AND of the two operands. Neither operation returns its result: only the flags are kept, in a small flags register that loads on a clock edge when the write enable is high.

A 4-bit condition code selects one predicate over the stored flags. The taken output follows the code combinationally. It therefore reflects the flags captured by the most recent enabled update, and never the operands that are present on the current cycle. The operand width is a parameter. The subtractor can be a behavioural subtraction or an explicit ripple borrow chain, chosen by a parameter.

Top module: `flagbr_top`

## Requirements
- R1: While rst_n is low, and after rst_n is released with no update, all four flags read 0.
- R2: The flags register loads on a rising clock edge only when flag_we_i is 1. When flag_we_i is 0, the flags keep their value whatever the operands and the operation select do.
- R3: With op_test_i = 0 (compare), the block forms r = dst_i − src_i modulo 2^WIDTH. ZF is (r == 0) and SF is the MSB of r. CF is 1 exactly when dst_i < src_i as unsigned values. OF is 1 exactly when the signed difference falls outside the signed WIDTH-bit range.
- R4: With op_test_i = 1 (test), the block forms r = dst_i & src_i. ZF is (r == 0), SF is the MSB of r, and CF and OF are both 0.
- R5: Condition code 0 is always taken. Codes 13, 14 and 15 are never taken.
- R6: Code 1 (equal) is taken when ZF = 1. Code 2 (not equal) is taken when ZF = 0.
- R7: The signed codes are taken as follows:
  - code 3 (greater): ZF = 0 and SF = OF.
  - code 4 (greater or equal): SF = OF.
  - code 5 (less): SF ≠ OF.
  - code 6 (less or equal): SF ≠ OF or ZF = 1.
- R8: The unsigned codes are taken as follows:
  - code 7 (above): CF = 0 and ZF = 0.
  - code 8 (above or equal): CF = 0.
  - code 9 (below): CF = 1.
  - code 10 (below or equal): CF = 1 or ZF = 1.
- R9: Code 11 (negative) is taken when SF = 1. Code 12 (not negative) is taken when SF = 0.
- R10: taken_o depends only on the stored flags and cond_i. A change of cond_i shows on taken_o in the same cycle, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dst_i | input | WIDTH | Destination operand (minuend for compare) |
| src_i | input | WIDTH | Source operand (subtrahend for compare) |
| op_test_i | input | 1 | 0 = compare (subtract), 1 = test (AND) |
| flag_we_i | input | 1 | Load the flags register on this edge |
| cond_i | input | 4 | Condition code for the branch decision |
| zf_o | output | 1 | Stored zero flag |
| sf_o | output | 1 | Stored sign flag |
| cf_o | output | 1 | Stored carry/borrow flag |
| of_o | output | 1 | Stored signed overflow flag |
| taken_o | output | 1 | Selected condition holds on the stored flags |

## Verification
The bench builds the block with WIDTH = 4 and RIPPLE_SUB = 1, so that the explicit borrow chain is the subtractor under test. At four bits every pair of operands can be swept under both operations. That sweep reaches every borrow and signed-overflow corner: the most negative value minus a positive value, zero minus the largest value, and operands that are equal. For each stored flag set, all sixteen condition codes are then evaluated, and one further cycle with the write enable low and disturbed operands confirms that the flags and the decision do not move.

// File: rtl/flagbr_pkg.sv
package flagbr_pkg;

   typedef struct packed {
      logic zf;
      logic sf;
      logic cf;
      logic of;
   } flags_t;

   typedef enum logic [3:0] {
      CC_ALWAYS = 4'd0,
      CC_EQ     = 4'd1,
      CC_NE     = 4'd2,
      CC_SGT    = 4'd3,
      CC_SGE    = 4'd4,
      CC_SLT    = 4'd5,
      CC_SLE    = 4'd6,
      CC_UGT    = 4'd7,
      CC_UGE    = 4'd8,
      CC_ULT    = 4'd9,
      CC_ULE    = 4'd10,
      CC_NEG    = 4'd11,
      CC_POS    = 4'd12,
      CC_RSV13  = 4'd13,
      CC_RSV14  = 4'd14,
      CC_RSV15  = 4'd15
   } cond_e;

   localparam int unsigned COND_W = 4;

endpackage

// File: rtl/flagbr_sub.sv
// Subtractor producing dst - src and an unsigned borrow.
module flagbr_sub #(
   parameter int unsigned WIDTH      = 64,
   parameter bit          RIPPLE_SUB = 1'b0
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] diff_o,
   output logic             borrow_o
);

   generate
      if (RIPPLE_SUB) begin : g_ripple
         // a + ~b + 1 with an explicit carry chain; borrow is the inverted carry out.
         logic [WIDTH:0] carry;
         assign carry[0] = 1'b1;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            logic nb;
            logic p;
            assign nb         = ~b_i[i];
            assign p          = a_i[i] ^ nb;
            assign diff_o[i]  = p ^ carry[i];
            assign carry[i+1] = (a_i[i] & nb) | (p & carry[i]);
         end
         assign borrow_o = ~carry[WIDTH];
      end else begin : g_behav
         logic [WIDTH:0] wide;
         assign wide     = {1'b0, a_i} - {1'b0, b_i};
         assign diff_o   = wide[WIDTH-1:0];
         assign borrow_o = wide[WIDTH];
      end
   endgenerate

endmodule

// File: rtl/flagbr_flaggen.sv
// Next-flag computation for compare and test.
module flagbr_flaggen
   import flagbr_pkg::*;
#(
   parameter int unsigned WIDTH      = 64,
   parameter bit          RIPPLE_SUB = 1'b0
) (
   input  logic [WIDTH-1:0] dst_i,
   input  logic [WIDTH-1:0] src_i,
   input  logic             op_test_i,
   output flags_t           next_o
);

   localparam int unsigned MSB = WIDTH - 1;

   logic [WIDTH-1:0] diff;
   logic             borrow;
   logic [WIDTH-1:0] conj;
   logic             ovf;

   flagbr_sub #(
      .WIDTH      (WIDTH),
      .RIPPLE_SUB (RIPPLE_SUB)
   ) u_sub (
      .a_i      (dst_i),
      .b_i      (src_i),
      .diff_o   (diff),
      .borrow_o (borrow)
   );

   assign conj = dst_i & src_i;
   // Signed overflow: operands differ in sign and the result sign departs from dst.
   assign ovf  = (dst_i[MSB] ^ src_i[MSB]) & (diff[MSB] ^ dst_i[MSB]);

   always_comb begin
      if (op_test_i) begin
         next_o.zf = (conj == '0);
         next_o.sf = conj[MSB];
         next_o.cf = 1'b0;
         next_o.of = 1'b0;
      end else begin
         next_o.zf = (diff == '0);
         next_o.sf = diff[MSB];
         next_o.cf = borrow;
         next_o.of = ovf;
      end
   end

endmodule

// File: rtl/flagbr_flagreg.sv
// Flags register with load enable.
module flagbr_flagreg
   import flagbr_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   we_i,
   input  flags_t d_i,
   output flags_t q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o <= '0;
      end else if (we_i) begin
         q_o <= d_i;
      end
   end

endmodule

// File: rtl/flagbr_condeval.sv
// Branch predicate over the stored flags.
module flagbr_condeval
   import flagbr_pkg::*;
(
   input  flags_t            flags_i,
   input  logic [COND_W-1:0] cond_i,
   output logic              taken_o
);

   logic sne;

   assign sne = flags_i.sf ^ flags_i.of;

   always_comb begin
      unique case (cond_e'(cond_i))
         CC_ALWAYS: taken_o = 1'b1;
         CC_EQ:     taken_o = flags_i.zf;
         CC_NE:     taken_o = ~flags_i.zf;
         CC_SGT:    taken_o = ~flags_i.zf & ~sne;
         CC_SGE:    taken_o = ~sne;
         CC_SLT:    taken_o = sne;
         CC_SLE:    taken_o = sne | flags_i.zf;
         CC_UGT:    taken_o = ~flags_i.cf & ~flags_i.zf;
         CC_UGE:    taken_o = ~flags_i.cf;
         CC_ULT:    taken_o = flags_i.cf;
         CC_ULE:    taken_o = flags_i.cf | flags_i.zf;
         CC_NEG:    taken_o = flags_i.sf;
         CC_POS:    taken_o = ~flags_i.sf;
         default:   taken_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/flagbr_top.sv
module flagbr_top
   import flagbr_pkg::*;
#(
   parameter int unsigned WIDTH      = 64,
   parameter bit          RIPPLE_SUB = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] dst_i,
   input  logic [WIDTH-1:0] src_i,
   input  logic             op_test_i,
   input  logic             flag_we_i,
   input  logic [3:0]       cond_i,
   output logic             zf_o,
   output logic             sf_o,
   output logic             cf_o,
   output logic             of_o,
   output logic             taken_o
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("flagbr_top: WIDTH must be at least 2");
      end
   endgenerate

   flags_t next_flags;
   flags_t cur_flags;

   flagbr_flaggen #(
      .WIDTH      (WIDTH),
      .RIPPLE_SUB (RIPPLE_SUB)
   ) u_gen (
      .dst_i     (dst_i),
      .src_i     (src_i),
      .op_test_i (op_test_i),
      .next_o    (next_flags)
   );

   flagbr_flagreg u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (flag_we_i),
      .d_i   (next_flags),
      .q_o   (cur_flags)
   );

   flagbr_condeval u_cond (
      .flags_i (cur_flags),
      .cond_i  (cond_i),
      .taken_o (taken_o)
   );

   assign zf_o = cur_flags.zf;
   assign sf_o = cur_flags.sf;
   assign cf_o = cur_flags.cf;
   assign of_o = cur_flags.of;

endmodule

// File: rtl/flagbr_chk.sv
module flagbr_chk #(
   parameter int unsigned WIDTH      = 64,
   parameter bit          RIPPLE_SUB = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] dst_i,
   input logic [WIDTH-1:0] src_i,
   input logic             op_test_i,
   input logic             flag_we_i,
   input logic [3:0]       cond_i,
   input logic             zf_o,
   input logic             sf_o,
   input logic             cf_o,
   input logic             of_o,
   input logic             taken_o
);

   // R1: flags are clear while reset is held
   always @(negedge clk) begin
      if (!rst_n) begin
         a_r1_reset_clear: assert ({zf_o, sf_o, cf_o, of_o} == 4'b0000)
            else $error("R1 flags not clear in reset");
      end
   end

   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_we_i |=> $stable({zf_o, sf_o, cf_o, of_o}))
      else $error("R2 flags moved without enable");

   a_r3_equal_operands: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we_i && !op_test_i && dst_i == src_i) |=> (zf_o && !cf_o && !of_o))
      else $error("R3 compare of equal operands");

   a_r4_test_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we_i && op_test_i) |=> (!cf_o && !of_o))
      else $error("R4 test left CF/OF set");

   a_r5_always: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_i == 4'd0) |-> taken_o)
      else $error("R5 always code not taken");

   a_r6_equal: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_i == 4'd1) |-> (taken_o == zf_o))
      else $error("R6 equal code mismatch");

   a_r7_signed_less: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_i == 4'd5) |-> (taken_o == (sf_o ^ of_o)))
      else $error("R7 signed less mismatch");

   a_r8_below: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_i == 4'd9) |-> (taken_o == cf_o))
      else $error("R8 below mismatch");

   a_r9_negative: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_i == 4'd11) |-> (taken_o == sf_o))
      else $error("R9 negative mismatch");

endmodule

bind flagbr_top flagbr_chk #(.WIDTH(WIDTH), .RIPPLE_SUB(RIPPLE_SUB)) u_chk (.*);

// File: tb/tb_flagbr_top.sv
`timescale 1ns/100ps
module tb_flagbr_top;

   localparam int W = 4;
   localparam int MASK = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] dst_i = '0;
   logic [W-1:0] src_i = '0;
   logic         op_test_i = 1'b0;
   logic         flag_we_i = 1'b0;
   logic [3:0]   cond_i = 4'd0;
   logic         zf_o, sf_o, cf_o, of_o, taken_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   flagbr_top #(.WIDTH(W), .RIPPLE_SUB(1'b1)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .dst_i     (dst_i),
      .src_i     (src_i),
      .op_test_i (op_test_i),
      .flag_we_i (flag_we_i),
      .cond_i    (cond_i),
      .zf_o      (zf_o),
      .sf_o      (sf_o),
      .cf_o      (cf_o),
      .of_o      (of_o),
      .taken_o   (taken_o)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic bit exp_taken(input int c, input bit z, input bit s, input bit cy, input bit o);
      case (c)
         0:  return 1'b1;               // R5
         1:  return z;                  // R6
         2:  return !z;                 // R6
         3:  return !z && (s == o);     // R7
         4:  return s == o;             // R7
         5:  return s != o;             // R7
         6:  return (s != o) || z;      // R7
         7:  return !cy && !z;          // R8
         8:  return !cy;                // R8
         9:  return cy;                 // R8
         10: return cy || z;            // R8
         11: return s;                  // R9
         12: return !s;                 // R9
         default: return 1'b0;          // R5 codes 13..15
      endcase
   endfunction

   function automatic string cond_req(input int c);
      if (c == 0 || c >= 13) return "R5";
      if (c <= 2) return "R6";
      if (c <= 6) return "R7";
      if (c <= 10) return "R8";
      return "R9";
   endfunction

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      check("R1", {zf_o, sf_o, cf_o, of_o}, 0);
      rst_n = 1'b1;
      @(posedge clk); #2;
      check("R1", {zf_o, sf_o, cf_o, of_o}, 0);
      cond_i = 4'd0; #0.5;
      check("R5", taken_o, 1);
      cond_i = 4'd1; #0.5;
      check("R6", taken_o, 0);

      for (int op = 0; op < 2; op++) begin
         for (int a = 0; a <= MASK; a++) begin
            for (int b = 0; b <= MASK; b++) begin
               int r, sa, sb, sd;
               bit ez, es, ec, eo;
               string fr;
               if (op == 0) begin
                  r  = (a - b) & MASK;
                  sa = (a > MASK / 2) ? a - (MASK + 1) : a;
                  sb = (b > MASK / 2) ? b - (MASK + 1) : b;
                  sd = sa - sb;
                  ec = (a < b);
                  eo = (sd > MASK / 2) || (sd < -(MASK / 2) - 1);
                  fr = "R3";
               end else begin
                  r  = a & b;
                  ec = 1'b0;
                  eo = 1'b0;
                  fr = "R4";
               end
               ez = (r == 0);
               es = r[W-1];

               @(negedge clk);
               dst_i = W'(a);
               src_i = W'(b);
               op_test_i = op[0];
               flag_we_i = 1'b1;
               @(posedge clk); #1;
               flag_we_i = 1'b0;
               check(fr, {zf_o, sf_o, cf_o, of_o}, {ez, es, ec, eo});

               // R10: sweep codes within the cycle, no clock edge needed
               for (int c = 0; c < 16; c++) begin
                  cond_i = 4'(c);
                  #0.5;
                  check(cond_req(c), taken_o, exp_taken(c, ez, es, ec, eo));
               end

               // R2 / R10: disturb operands with enable low
               dst_i = ~W'(a);
               src_i = W'(b + 5);
               op_test_i = ~op[0];
               cond_i = 4'd5;
               @(posedge clk); #2;
               check("R2", {zf_o, sf_o, cf_o, of_o}, {ez, es, ec, eo});
               check("R10", taken_o, exp_taken(5, ez, es, ec, eo));
            end
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule